// File: doc/BRIEF.md
# DMA Controller Register Bank with Interrupt Capture

This block is the software-visible register file of a multi-channel DMA controller. A host issues single 32-bit word reads and writes by byte offset. The low part of the offset space holds a small set of controller-wide registers: a control word, two interrupt mask words and two interrupt source words. Above a fixed channel base, each channel owns a window of eight words. The window holds a control/status word, a size word, source and destination addresses each with its own address mask, a descriptor pointer and a software pointer.

The transfer engine is outside this block. It sees each channel's control/status word on a flat output bus. It reports per-channel chunk-done, done and error pulses back into the bank. The bank turns those pulses into status bits and interrupt flags. When a channel's event enable and its bit in mask A are both set, the bank loads source A with that channel's one-hot bit, which overwrites any earlier value. The single controller interrupt is derived from source A and mask A.

Top module: `dmarb_regbank`

## Requirements
- R1: Controller registers sit at offsets 0x00 (control), 0x04 (mask A), 0x08 (mask B), 0x0C (source A) and 0x10 (source B). Channel c register r sits at 0x20 + 0x20*c + 4*r, with r = 0 control/status, 1 size, 2 source address, 3 source mask, 4 destination address, 5 destination mask, 6 descriptor pointer, 7 software pointer. Every register except the two control words reads back the last value written.
- R2: Each request cycle produces exactly one response, with `rsp_valid` high in the following cycle and low otherwise.
- R3: An offset whose two low bits are not zero gets `rsp_err`=1 and read data 0, and changes no register.
- R4: Offsets 0x14, 0x18 and 0x1C, and any offset at or above 0x120, read as 0 with `rsp_err`=1.
- R5: After reset every register reads 0, except both address mask registers of every channel, which read 0xFFFFFFFC. `irq` is low.
- R6: A channel control/status write changes only bits [10:0]. Those bits are: 0 enable, 1 handshake, 2 source increment, 3 destination increment, 4 source select, 5 destination select, 6 descriptor use, 7 auto-restart, 8 error interrupt enable, 9 done interrupt enable, 10 chunk interrupt enable. The only other effect is that writing bit 0 as 1 clears the done bit 12.
- R7: A channel control/status read returns its value from before the access. The same access clears bit 13 (error), bit 14 (chunk interrupt), bit 15 (done interrupt) and bit 16 (error interrupt). Bit 12 (done) is kept.
- R8: A done pulse sets bit 12 and clears bit 0. An error pulse sets bit 13 and clears bit 0. A chunk pulse changes no status bit. Bits set by a pulse survive a read-clear in the same cycle.
- R9: A pulse raises an interrupt only if its enable bit (8, 9 or 10) and the channel's bit in mask A are both set. The interrupt sets bit 16, 15 or 14 and loads source A with 1<<c, replacing its old value. When channels fire in the same cycle, the lowest-numbered one is loaded.
- R10: `irq` is the OR of (source A AND mask A). It stays high until source A or mask A is rewritten.
- R11: The controller control word stores nothing and reads 0. Writing it with bit 0 (pause) set returns `rsp_err`=1; otherwise it returns no error.
- R12: `ch_csr_o[32*c+31:32*c]` always shows channel c's control/status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW (9) | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Illegal or unsupported access |
| evt_chunk | input | NCH | Per-channel chunk-complete pulse |
| evt_done | input | NCH | Per-channel transfer-done pulse |
| evt_err | input | NCH | Per-channel error/abort pulse |
| ch_csr_o | output | 32*NCH | All channel control/status words |
| irq | output | 1 | Controller interrupt |

## Verification
The address decoder is swept over every register of every channel with values derived from the channel and register index. This separates a mis-scaled stride or an aliased window from a correct map. The event logic is swept over every channel and event kind, each with the mask A bit on and off, and with the event enable off. This shows whether interrupt gating uses both conditions and whether source A is loaded with the right one-hot bit. Sequences of firings on different channels, and two channels firing together, tell an overwrite from an OR and check which channel takes priority. A read-clear that lands in the same cycle as an error pulse shows which of the two wins.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    localparam logic [31:0] CH_BASE    = 32'h20;
    localparam logic [31:0] CH_STRIDE  = 32'h20;
    localparam logic [31:0] MASK_RST   = 32'hFFFF_FFFC;
    localparam logic [31:0] CSR_WMASK  = 32'h0000_07FF;
    localparam logic [31:0] CSR_RDCLR  = 32'h0001_E000;

    localparam int B_EN        = 0;
    localparam int B_IE_ERR    = 8;
    localparam int B_IE_DONE   = 9;
    localparam int B_IE_CHUNK  = 10;
    localparam int B_DONE      = 12;
    localparam int B_ERR       = 13;
    localparam int B_INT_CHUNK = 14;
    localparam int B_INT_DONE  = 15;
    localparam int B_INT_ERR   = 16;

    typedef enum logic [2:0] {
        CR_CSR, CR_SIZE, CR_SRC, CR_SRCMSK, CR_DST, CR_DSTMSK, CR_DESC, CR_SWPTR
    } chreg_e;

    typedef enum logic [2:0] {
        GR_CTRL, GR_MSKA, GR_MSKB, GR_SRCA, GR_SRCB
    } greg_e;

    typedef struct packed {
        logic [31:0] csr;
        logic [31:0] size;
        logic [31:0] src;
        logic [31:0] src_mask;
        logic [31:0] dst;
        logic [31:0] dst_mask;
        logic [31:0] desc;
        logic [31:0] swptr;
    } chregs_t;

    typedef struct packed {
        logic       glob;
        logic       chan;
        logic       bad;
        logic [2:0] reg_idx;
    } dec_t;

    function automatic logic [31:0] lowest_one(input logic [31:0] v);
        return v & (~v + 32'd1);
    endfunction

endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
    import dmarb_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 9,
    parameter int CW  = 3
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec,
    output logic [CW-1:0] ch_idx
);
    localparam logic [31:0] CH_END = CH_BASE + CH_STRIDE * NCH;

    logic [31:0] a32;
    logic [31:0] off32;

    always_comb begin
        a32     = 32'(addr);
        off32   = a32 - CH_BASE;
        dec     = '0;
        ch_idx  = '0;
        dec.reg_idx = a32[4:2];
        if (a32[1:0] != 2'b00) begin
            dec.bad = 1'b1;
        end else if (a32 < CH_BASE) begin
            if (a32[4:2] <= 3'd4) dec.glob = 1'b1;
            else                  dec.bad  = 1'b1;
        end else if (a32 < CH_END) begin
            dec.chan = 1'b1;
            ch_idx   = off32[CW+4:5];
        end else begin
            dec.bad = 1'b1;
        end
    end
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
    import dmarb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        rd,
    input  chreg_e      sel,
    input  logic [31:0] wdata,
    input  logic        mask_bit,
    input  logic        evt_chunk,
    input  logic        evt_done,
    input  logic        evt_err,
    output logic [31:0] rdata,
    output logic [31:0] csr_o,
    output logic        fire
);
    chregs_t r;
    chregs_t r_nxt;
    logic    f_chunk, f_done, f_err;

    assign f_chunk = evt_chunk & r.csr[B_IE_CHUNK] & mask_bit;
    assign f_done  = evt_done  & r.csr[B_IE_DONE]  & mask_bit;
    assign f_err   = evt_err   & r.csr[B_IE_ERR]   & mask_bit;
    assign fire    = f_chunk | f_done | f_err;
    assign csr_o   = r.csr;

    always_comb begin
        unique case (sel)
            CR_CSR:    rdata = r.csr;
            CR_SIZE:   rdata = r.size;
            CR_SRC:    rdata = r.src;
            CR_SRCMSK: rdata = r.src_mask;
            CR_DST:    rdata = r.dst;
            CR_DSTMSK: rdata = r.dst_mask;
            CR_DESC:   rdata = r.desc;
            CR_SWPTR:  rdata = r.swptr;
            default:   rdata = '0;
        endcase
    end

    always_comb begin
        r_nxt = r;
        if (wr) begin
            unique case (sel)
                CR_CSR: begin
                    r_nxt.csr = (r.csr & ~CSR_WMASK) | (wdata & CSR_WMASK);
                    if (wdata[B_EN]) r_nxt.csr[B_DONE] = 1'b0;
                end
                CR_SIZE:   r_nxt.size     = wdata;
                CR_SRC:    r_nxt.src      = wdata;
                CR_SRCMSK: r_nxt.src_mask = wdata;
                CR_DST:    r_nxt.dst      = wdata;
                CR_DSTMSK: r_nxt.dst_mask = wdata;
                CR_DESC:   r_nxt.desc     = wdata;
                CR_SWPTR:  r_nxt.swptr    = wdata;
                default: ;
            endcase
        end
        if (rd && sel == CR_CSR) r_nxt.csr = r_nxt.csr & ~CSR_RDCLR;
        // engine pulses are applied last so they win over a same-cycle clear
        if (evt_done) begin
            r_nxt.csr[B_DONE] = 1'b1;
            r_nxt.csr[B_EN]   = 1'b0;
        end
        if (evt_err) begin
            r_nxt.csr[B_ERR] = 1'b1;
            r_nxt.csr[B_EN]  = 1'b0;
        end
        if (f_chunk) r_nxt.csr[B_INT_CHUNK] = 1'b1;
        if (f_done)  r_nxt.csr[B_INT_DONE]  = 1'b1;
        if (f_err)   r_nxt.csr[B_INT_ERR]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r          <= '0;
            r.src_mask <= MASK_RST;
            r.dst_mask <= MASK_RST;
        end else begin
            r <= r_nxt;
        end
    end

    // R7
    rdclr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && sel == CR_CSR && !evt_chunk && !evt_done && !evt_err)
        |=> (r.csr[16:13] == 4'b0000));

    // R6
    wmask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == CR_CSR && !wdata[B_EN] && !evt_chunk && !evt_done && !evt_err)
        |=> (r.csr[31:11] == $past(r.csr[31:11])));

    // R8
    done_evt_chk: assert property (@(posedge clk) disable iff (rst)
        evt_done |=> (r.csr[B_DONE] && !r.csr[B_EN]));

    // R9
    no_int_chk: assert property (@(posedge clk) disable iff (rst)
        (!mask_bit && !rd) |=> (r.csr[16:14] == $past(r.csr[16:14])));
endmodule

// File: rtl/dmarb_global.sv
module dmarb_global
    import dmarb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr,
    input  greg_e          sel,
    input  logic [31:0]    wdata,
    input  logic [NCH-1:0] fire,
    output logic [31:0]    rdata,
    output logic [31:0]    mask_a_o,
    output logic           irq
);
    logic [31:0] mask_a, mask_b, src_a, src_b;

    assign mask_a_o = mask_a;
    assign irq      = |(src_a & mask_a);

    always_comb begin
        unique case (sel)
            GR_MSKA: rdata = mask_a;
            GR_MSKB: rdata = mask_b;
            GR_SRCA: rdata = src_a;
            GR_SRCB: rdata = src_b;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_a <= '0;
            mask_b <= '0;
            src_a  <= '0;
            src_b  <= '0;
        end else begin
            if (wr && sel == GR_MSKA) mask_a <= wdata;
            if (wr && sel == GR_MSKB) mask_b <= wdata;
            if (wr && sel == GR_SRCB) src_b  <= wdata;
            if (|fire)                   src_a <= lowest_one(32'(fire));
            else if (wr && sel == GR_SRCA) src_a <= wdata;
        end
    end

    // R9
    srca_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (|fire) |=> ($countones(src_a) == 1));

    // R10
    srca_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(|fire) && !(wr && sel == GR_SRCA)) |=> $stable(src_a));
endmodule

// File: rtl/dmarb_regbank.sv
module dmarb_regbank
    import dmarb_pkg::*;
#(
    parameter int  NCH = 8,
    localparam int AW  = $clog2(CH_BASE + CH_STRIDE * NCH),
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [31:0]      req_wdata,
    output logic             rsp_valid,
    output logic [31:0]      rsp_rdata,
    output logic             rsp_err,
    input  logic [NCH-1:0]   evt_chunk,
    input  logic [NCH-1:0]   evt_done,
    input  logic [NCH-1:0]   evt_err,
    output logic [32*NCH-1:0] ch_csr_o,
    output logic             irq
);
    dec_t           dec;
    logic [CW-1:0]  ch_idx;
    logic [31:0]    gl_rdata, mask_a;
    logic [31:0]    ch_rdata [NCH];
    logic [NCH-1:0] fire;
    logic           gl_wr, pause_err;
    logic [31:0]    rd_mux;

    dmarb_decode #(.NCH(NCH), .AW(AW), .CW(CW)) u_dec (
        .addr(req_addr), .dec(dec), .ch_idx(ch_idx)
    );

    assign gl_wr     = req_valid & req_write & dec.glob;
    assign pause_err = gl_wr & (dec.reg_idx == 3'(GR_CTRL)) & req_wdata[0];

    dmarb_global #(.NCH(NCH)) u_glob (
        .clk(clk), .rst(rst), .wr(gl_wr), .sel(greg_e'(dec.reg_idx)),
        .wdata(req_wdata), .fire(fire), .rdata(gl_rdata),
        .mask_a_o(mask_a), .irq(irq)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = req_valid & dec.chan & (ch_idx == CW'(i));
        dmarb_chan u_chan (
            .clk(clk), .rst(rst),
            .wr(hit & req_write), .rd(hit & ~req_write),
            .sel(chreg_e'(dec.reg_idx)), .wdata(req_wdata),
            .mask_bit(mask_a[i]),
            .evt_chunk(evt_chunk[i]), .evt_done(evt_done[i]), .evt_err(evt_err[i]),
            .rdata(ch_rdata[i]), .csr_o(ch_csr_o[32*i +: 32]), .fire(fire[i])
        );
    end

    always_comb begin
        if (dec.glob)      rd_mux = gl_rdata;
        else if (dec.chan) rd_mux = ch_rdata[ch_idx];
        else               rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
            rsp_err   <= req_valid && (dec.bad || pause_err);
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3
    unaligned_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));
endmodule

// File: tb/dmarb_regbank_bench.sv
module dmarb_regbank_bench;
    localparam int NCH = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [8:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              rsp_err;
    logic [NCH-1:0]    evt_chunk = '0;
    logic [NCH-1:0]    evt_done = '0;
    logic [NCH-1:0]    evt_err = '0;
    logic [32*NCH-1:0] ch_csr_o;
    logic              irq;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] rd_data;
    logic        rd_err;

    always #2 clk = ~clk;

    dmarb_regbank #(.NCH(NCH)) u_dmarb_regbank (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .evt_chunk(evt_chunk),
        .evt_done(evt_done), .evt_err(evt_err), .ch_csr_o(ch_csr_o), .irq(irq)
    );

    function automatic int cha(int c, int r);
        return 32'h20 + 32'h20 * c + 4 * r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit w, input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a[8:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd_data = rsp_rdata; rd_err = rsp_err;
        if (rsp_valid !== 1'b1) chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    endtask

    task automatic pulse(input int kind, input logic [NCH-1:0] v);
        @(negedge clk);
        if (kind == 0) evt_chunk = v;
        else if (kind == 1) evt_done = v;
        else evt_err = v;
        @(negedge clk);
        evt_chunk = '0; evt_done = '0; evt_err = '0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] exp, base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        chk("R5 irq", {31'b0, irq}, 32'h0);
        chk("R2 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
        for (int g = 0; g < 5; g++) begin
            acc(0, 4 * g, 0);
            chk("R5 global reset", rd_data, 32'h0);
        end
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < 8; r++) begin
                acc(0, cha(c, r), 0);
                chk("R5 channel reset", rd_data, (r == 3 || r == 5) ? 32'hFFFF_FFFC : 32'h0);
            end

        // R1 full map sweep, written first then read to expose aliasing
        for (int c = 0; c < NCH; c++)
            for (int r = 1; r < 8; r++)
                acc(1, cha(c, r), 32'hA500_0000 ^ (c << 12) ^ (r << 4) ^ (c * 7 + r));
        acc(1, 32'h04, 32'h1111_0000); acc(1, 32'h08, 32'h2222_0000);
        acc(1, 32'h0C, 32'h0000_3300); acc(1, 32'h10, 32'h4444_0000);
        for (int c = 0; c < NCH; c++)
            for (int r = 1; r < 8; r++) begin
                acc(0, cha(c, r), 0);
                chk("R1 channel readback", rd_data, 32'hA500_0000 ^ (c << 12) ^ (r << 4) ^ (c * 7 + r));
            end
        acc(0, 32'h04, 0); chk("R1 mask A", rd_data, 32'h1111_0000);
        acc(0, 32'h08, 0); chk("R1 mask B", rd_data, 32'h2222_0000);
        acc(0, 32'h0C, 0); chk("R1 source A", rd_data, 32'h0000_3300);
        acc(0, 32'h10, 0); chk("R1 source B", rd_data, 32'h4444_0000);
        chk("R10 irq no overlap", {31'b0, irq}, 32'h0);
        acc(1, 32'h04, 32'h0000_0100);
        chk("R10 irq on overlap", {31'b0, irq}, 32'h1);
        acc(1, 32'h04, 0);
        acc(1, 32'h0C, 0);

        // R6 write mask, R12 exported CSR
        acc(1, cha(3, 0), 32'hFFFF_FFFF);
        acc(0, cha(3, 0), 0); chk("R6 csr write mask", rd_data, 32'h0000_07FF);
        acc(0, cha(3, 0), 0); chk("R7 no status to clear", rd_data, 32'h0000_07FF);
        for (int c = 0; c < NCH; c++) acc(1, cha(c, 0), 32'(c * 2 + 2));
        for (int c = 0; c < NCH; c++)
            chk("R12 ch_csr_o slice", ch_csr_o[32*c +: 32], 32'(c * 2 + 2));

        // R8 R9 R10 R7 event sweep
        base = 32'h0000_0701;
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 3; k++)
                for (int m = 0; m < 2; m++) begin
                    acc(1, 32'h04, m ? (32'h1 << c) : 32'h0);
                    acc(1, 32'h0C, 0);
                    acc(1, cha(c, 0), base);
                    pulse(k, NCH'(1) << c);
                    chk("R10 irq after event", {31'b0, irq}, 32'(m));
                    if (k == 0)      exp = base | (m ? 32'h4000 : 32'h0);
                    else if (k == 1) exp = (base & ~32'h1) | 32'h1000 | (m ? 32'h8000 : 32'h0);
                    else             exp = (base & ~32'h1) | 32'h2000 | (m ? 32'h1_0000 : 32'h0);
                    acc(0, cha(c, 0), 0); chk("R8 R9 csr after event", rd_data, exp);
                    acc(0, cha(c, 0), 0); chk("R7 csr after read-clear", rd_data, exp & ~32'h0001_E000);
                    acc(0, 32'h0C, 0); chk("R9 source A", rd_data, m ? (32'h1 << c) : 32'h0);
                    chk("R10 irq held", {31'b0, irq}, 32'(m));
                end
        acc(1, 32'h0C, 0);
        chk("R10 irq cleared by rewrite", {31'b0, irq}, 32'h0);

        // R9 event enables off: no interrupt even with mask set
        acc(1, 32'h04, 32'hFF);
        for (int c = 0; c < NCH; c++) begin
            acc(1, cha(c, 0), 32'h1);
            pulse(0, NCH'(1) << c);
            acc(0, cha(c, 0), 0); chk("R9 enable off csr", rd_data, 32'h1);
        end
        acc(0, 32'h0C, 0); chk("R9 enable off source A", rd_data, 32'h0);

        // R9 overwrite, not OR; lowest channel wins
        for (int c = 0; c < NCH; c++) acc(1, cha(c, 0), 32'h401);
        pulse(0, 8'h20);
        acc(0, 32'h0C, 0); chk("R9 source A ch5", rd_data, 32'h20);
        pulse(0, 8'h04);
        acc(0, 32'h0C, 0); chk("R9 source A overwrite", rd_data, 32'h04);
        pulse(0, 8'h48);
        acc(0, 32'h0C, 0); chk("R9 source A priority", rd_data, 32'h08);

        // R8 pulse wins over same-cycle read-clear
        for (int c = 0; c < NCH; c++) acc(0, cha(c, 0), 0);
        acc(1, cha(0, 0), 32'h501);
        pulse(0, 8'h01);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 9'(cha(0, 0)); evt_err = 8'h01;
        @(negedge clk);
        req_valid = 1'b0; evt_err = '0;
        chk("R7 read returns prior", rsp_rdata, 32'h0000_4501);
        acc(0, cha(0, 0), 0); chk("R8 pulse beats read-clear", rd_data, 32'h0001_2500);
        acc(0, cha(0, 0), 0); chk("R7 second read", rd_data, 32'h0000_0500);
        // R6 enable write clears done
        acc(1, cha(1, 0), 32'h001);
        pulse(1, 8'h02);
        acc(0, cha(1, 0), 0); chk("R8 done set", rd_data, 32'h0000_1000);
        acc(1, cha(1, 0), 32'h001);
        acc(0, cha(1, 0), 0); chk("R6 enable clears done", rd_data, 32'h0000_0001);

        // R3 unaligned
        acc(1, cha(2, 1), 32'h1234_5678);
        acc(1, cha(2, 1) + 1, 32'hDEAD_BEEF); chk("R3 unaligned write err", {31'b0, rd_err}, 32'h1);
        acc(0, cha(2, 1) + 2, 0);
        chk("R3 unaligned read err", {31'b0, rd_err}, 32'h1);
        chk("R3 unaligned read data", rd_data, 32'h0);
        acc(0, cha(2, 1), 0); chk("R3 no state change", rd_data, 32'h1234_5678);

        // R4 unmapped
        for (int a = 32'h14; a <= 32'h1C; a += 4) begin
            acc(0, a, 0);
            chk("R4 unmapped data", rd_data, 32'h0);
            chk("R4 unmapped err", {31'b0, rd_err}, 32'h1);
        end
        acc(0, 32'h120, 0); chk("R4 above range err", {31'b0, rd_err}, 32'h1);
        acc(0, 32'h1FC, 0); chk("R4 top err", {31'b0, rd_err}, 32'h1);
        acc(0, cha(7, 7), 0); chk("R4 last legal no err", {31'b0, rd_err}, 32'h0);

        // R11 controller control word
        acc(1, 32'h00, 32'h1); chk("R11 pause flagged", {31'b0, rd_err}, 32'h1);
        acc(1, 32'h00, 32'h2); chk("R11 no pause no err", {31'b0, rd_err}, 32'h0);
        acc(0, 32'h00, 0);
        chk("R11 reads zero", rd_data, 32'h0);
        chk("R11 read no err", {31'b0, rd_err}, 32'h0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule